// File: doc/BRIEF.md
# Serial Access Port for a 32 x 4 Display Memory

This block is the host-facing side of a segment display controller. A host drives three strobe-style lines: an active-low select, a write strobe and a read strobe. It also uses one data line whose output half is given here as a value plus an enable. With these lines the host can fill or inspect a 32-word, 4-bit display memory and send 9-bit configuration codes. All strobes pass through synchronizers into the system clock and are edge-detected, so the port runs entirely on `clk`.

Every transfer begins with select going low and a 3-bit operation prefix, clocked in on write-strobe rising edges. A data operation then takes a 6-bit start address, most significant bit first. After that it moves 4-bit words, least significant bit first, and the address steps on after each word. A command operation takes any number of 9-bit codes, each published as a one-cycle strobe. A second, read-only port lets the display scanner read any word at any time.

Top module: `disp_ram_serial_port`

## Requirements
- R1: While the synchronized select is high, strobes are ignored, the operation returns to idle, any partial prefix, address or word is dropped and `dat_oe` is low.
- R2: The prefix 3'b101 starts a write. Bits are taken on write-strobe rising edges. The 6-bit address comes MSB first, and only its low 5 bits pick the word. Each complete 4-bit word, sent LSB first, is stored at the current address.
- R3: The prefix 3'b110 starts a read. Each read-strobe falling edge puts the next bit of the current word, LSB first, on `dat_out`. `dat_oe` rises with the first such bit and stays high until select goes high.
- R4: The address advances by one after every complete word in write and read operations, and it wraps from 31 to 0.
- R5: The prefix 3'b111 starts a read-modify-write. The word at the current address can be read bit by bit on read-strobe edges, and the address advances only after a 4-bit word has been written back on write-strobe edges.
- R6: The prefix 3'b100 starts command mode. Each group of 9 bits, MSB first, yields a one-cycle `cmd_valid` pulse with the code on `cmd_code`, and any number of codes may follow one prefix.
- R7: A prefix whose first bit is 0 selects nothing. Later strobes change neither memory nor outputs until select goes high.
- R8: After reset every memory word is zero, and `dat_oe`, `dat_out` and `cmd_valid` are low.
- R9: `scan_data` always shows the word at `scan_addr`, independent of any serial activity.
- R10: If select rises on the same clock as the write-strobe edge that would complete a word, that word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from host |
| wr_n | input | 1 | Write strobe; bits taken on its rising edge |
| rd_n | input | 1 | Read strobe; bits driven after its falling edge |
| dat_in | input | 1 | Serial data from host |
| dat_out | output | 1 | Serial read data to host |
| dat_oe | output | 1 | Drive enable for the shared data line |
| cmd_valid | output | 1 | One-cycle strobe for a completed command code |
| cmd_code | output | 9 | Last completed command code |
| scan_addr | input | 5 | Display scanner word address |
| scan_data | output | 4 | Word at `scan_addr` |

## Verification
Two events can fall on the same clock: select being released and the write-strobe edge that completes a word. Both pass through synchronizers of equal depth, so they reach the logic together. The bench changes both lines on one clock edge after three bits of a word have been sent. It then reads that address back and expects the earlier contents, because release must win over the store. A second overlap is between the scanner read and a serial store. The bench compares the scan port against its model after each operation.

// File: rtl/disp_ram_serial_port.sv
module disp_ram_serial_port #(
  parameter int DEPTH    = 32,
  parameter int NIB_W    = 4,
  parameter int AFIELD_W = 6,
  parameter int CMD_W    = 9,
  parameter int SYNC     = 2,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             dat_in,
  output logic             dat_out,
  output logic             dat_oe,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_code,
  input  logic [IDX_W-1:0] scan_addr,
  output logic [NIB_W-1:0] scan_data
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam int RC_W  = $clog2(NIB_W);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_WR = 3'd2, S_RD = 3'd3,
                         S_RMW = 3'd4, S_CMD = 3'd5, S_DEAD = 3'd6;

  logic [SYNC-1:0] cs_sh, wr_sh, rd_sh, d_sh;
  logic wr_prev, rd_prev;
  logic [2:0] st, op;
  logic [CNT_W-1:0] cnt;
  logic [RC_W-1:0] rcnt;
  logic [CMD_W-1:0] sh;
  logic [NIB_W-1:0] wsh;
  logic [IDX_W-1:0] addr;
  logic [NIB_W-1:0] mem [DEPTH];

  wire cs_q    = cs_sh[SYNC-1];
  wire din     = d_sh[SYNC-1];
  wire wr_rise = wr_sh[SYNC-1] & ~wr_prev;
  wire rd_fall = ~rd_sh[SYNC-1] & rd_prev;
  wire [CMD_W:0]   sh_nx  = {sh, din};
  wire [NIB_W-1:0] wsh_nx = {din, wsh[NIB_W-1:1]};

  assign scan_data = mem[scan_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh <= '1; wr_sh <= '1; rd_sh <= '1; d_sh <= '0;
      wr_prev <= 1'b1; rd_prev <= 1'b1;
    end else begin
      cs_sh <= {cs_sh[SYNC-2:0], cs_n};
      wr_sh <= {wr_sh[SYNC-2:0], wr_n};
      rd_sh <= {rd_sh[SYNC-2:0], rd_n};
      d_sh  <= {d_sh[SYNC-2:0], dat_in};
      wr_prev <= wr_sh[SYNC-1];
      rd_prev <= rd_sh[SYNC-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= S_IDLE; cnt <= '0; rcnt <= '0;
      sh <= '0; wsh <= '0; addr <= '0;
      dat_out <= 1'b0; dat_oe <= 1'b0;
      cmd_valid <= 1'b0; cmd_code <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (cs_q) begin
        st <= S_IDLE; cnt <= '0; rcnt <= '0; dat_oe <= 1'b0;
      end else begin
        if (wr_rise) begin
          case (st)
            S_IDLE: begin
              sh <= sh_nx[CMD_W-1:0];
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(2)) begin
                cnt <= '0;
                case (sh_nx[2:0])
                  3'b101:  begin st <= S_ADDR; op <= S_WR;  end
                  3'b110:  begin st <= S_ADDR; op <= S_RD;  end
                  3'b111:  begin st <= S_ADDR; op <= S_RMW; end
                  3'b100:  st <= S_CMD;
                  default: st <= S_DEAD;
                endcase
              end
            end
            S_ADDR: begin
              sh <= sh_nx[CMD_W-1:0];
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(AFIELD_W - 1)) begin
                cnt <= '0; addr <= sh_nx[IDX_W-1:0]; st <= op; rcnt <= '0;
              end
            end
            S_WR, S_RMW: begin
              wsh <= wsh_nx;
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(NIB_W - 1)) begin
                cnt <= '0; mem[addr] <= wsh_nx; addr <= addr + 1'b1;
              end
            end
            S_CMD: begin
              sh <= sh_nx[CMD_W-1:0];
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(CMD_W - 1)) begin
                cnt <= '0; cmd_valid <= 1'b1; cmd_code <= sh_nx[CMD_W-1:0];
              end
            end
            default: ;
          endcase
        end
        if (rd_fall && (st == S_RD || st == S_RMW)) begin
          dat_out <= mem[addr][rcnt];
          dat_oe  <= 1'b1;
          rcnt    <= (rcnt == RC_W'(NIB_W - 1)) ? '0 : rcnt + 1'b1;
          if (st == S_RD && rcnt == RC_W'(NIB_W - 1)) addr <= addr + 1'b1;
        end
        if (st == S_RMW && wr_rise && cnt == CNT_W'(NIB_W - 1)) rcnt <= '0;
      end
    end
  end
endmodule

// File: rtl/disp_ram_serial_port_chk.sv
module disp_ram_serial_port_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_q,
  input logic [2:0]       st,
  input logic [IDX_W-1:0] addr,
  input logic             dat_oe,
  input logic             cmd_valid
);
  assert_select_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> (!dat_oe && st == 3'd0));

  assert_oe_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe && !cs_q) |-> (st == 3'd3 || st == 3'd4));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == $past(st) && (st == 3'd2 || st == 3'd3 || st == 3'd4) && addr != $past(addr))
      |-> addr == IDX_W'($past(addr) + 1'b1));

  assert_cmd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_cmd_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> st == 3'd5);
endmodule

bind disp_ram_serial_port disp_ram_serial_port_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .st(st), .addr(addr),
  .dat_oe(dat_oe), .cmd_valid(cmd_valid)
);

// File: tb/tb_disp_ram_serial_port.sv
module tb_disp_ram_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, dat_in = 1'b0;
  logic dat_out, dat_oe, cmd_valid;
  logic [8:0] cmd_code;
  logic [4:0] scan_addr = '0;
  logic [3:0] scan_data;

  int n_chk = 0, n_bad = 0;
  logic [3:0] model [32];
  logic [8:0] cmd_log [16];
  int cmd_n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  disp_ram_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .scan_addr(scan_addr), .scan_data(scan_data)
  );

  always @(negedge clk) if (cmd_valid && cmd_n < 16) begin
    cmd_log[cmd_n] = cmd_code; cmd_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic sel; cs_n = 1'b0; idle(4); endtask
  task automatic desel; cs_n = 1'b1; idle(5); endtask

  task automatic wbit(input bit b);
    wr_n = 1'b0; dat_in = b; idle(4);
    wr_n = 1'b1; idle(4);
  endtask

  task automatic rbit(output bit b);
    rd_n = 1'b0; idle(4);
    b = dat_out;
    rd_n = 1'b1; idle(4);
  endtask

  task automatic wprefix(input logic [2:0] p);
    for (int i = 2; i >= 0; i--) wbit(p[i]);
  endtask

  task automatic waddr(input logic [5:0] a);
    for (int i = 5; i >= 0; i--) wbit(a[i]);
  endtask

  task automatic wnib(input logic [3:0] v);
    for (int i = 0; i < 4; i++) wbit(v[i]);
  endtask

  task automatic rnib(output logic [3:0] v);
    bit b;
    for (int i = 0; i < 4; i++) begin rbit(b); v[i] = b; end
  endtask

  function automatic int nxt(input int a); return (a + 1) % 32; endfunction

  task automatic do_write(input logic [5:0] a6, input int n);
    int a = int'(a6[4:0]);
    logic [3:0] v;
    sel; wprefix(3'b101); waddr(a6);
    for (int k = 0; k < n; k++) begin
      v = 4'($urandom); wnib(v); model[a] = v; a = nxt(a);
    end
    desel;
  endtask

  task automatic do_read(input logic [5:0] a6, input int n, input string req);
    int a = int'(a6[4:0]);
    logic [3:0] v;
    sel; wprefix(3'b110); waddr(a6);
    for (int k = 0; k < n; k++) begin
      rnib(v);
      if (k == 0) chk(dat_oe === 1'b1, "R3 oe", int'(dat_oe), 1);
      chk(v === model[a], req, int'(v), int'(model[a]));
      a = nxt(a);
    end
    desel;
    chk(dat_oe === 1'b0, "R1 oe release", int'(dat_oe), 0);
  endtask

  task automatic scan_all(input string req);
    int bad = 0;
    for (int i = 0; i < 32; i++) begin
      scan_addr = 5'(i); #1;
      if (scan_data !== model[i]) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    logic [3:0] v;
    void'($urandom(32'd1621));
    for (int i = 0; i < 32; i++) model[i] = '0;
    idle(3); rst_n = 1'b1; idle(2);
    chk(dat_oe === 1'b0 && dat_out === 1'b0 && cmd_valid === 1'b0, "R8 outputs", int'({dat_oe, dat_out, cmd_valid}), 0);
    scan_all("R8 memory zero");

    do_write(6'd0, 32);
    do_read(6'd0, 32, "R2 R3 full pass");
    scan_all("R9 scan after write");
    for (int t = 0; t < 6; t++) begin
      logic [5:0] a = 6'($urandom);
      int n = 1 + int'($urandom % 6);
      do_write(a, n);
      do_read(6'(a[4:0]), n, "R2 random");
    end
    do_write(6'd30, 5);
    do_read(6'd30, 5, "R4 wrap write");
    do_read(6'd31, 3, "R4 wrap read");
    do_write(6'b100011, 2);
    do_read(6'd3, 2, "R2 address bit5 ignored");

    sel; wprefix(3'b111); waddr(6'd9);
    rnib(v); chk(v === model[9], "R5 rmw read", int'(v), int'(model[9]));
    rnib(v); chk(v === model[9], "R5 rmw reread no step", int'(v), int'(model[9]));
    wnib(4'h6); model[9] = 4'h6;
    rnib(v); chk(v === model[10], "R5 step after write", int'(v), int'(model[10]));
    wnib(4'hB); model[10] = 4'hB;
    desel;
    do_read(6'd9, 3, "R5 rmw result");

    sel; wprefix(3'b100);
    for (int i = 8; i >= 0; i--) wbit(1'(9'h1A5 >> i));
    for (int i = 8; i >= 0; i--) wbit(1'(9'h04E >> i));
    desel;
    chk(cmd_n == 2, "R6 count", cmd_n, 2);
    chk(cmd_log[0] === 9'h1A5, "R6 code0", int'(cmd_log[0]), 'h1A5);
    chk(cmd_log[1] === 9'h04E, "R6 code1", int'(cmd_log[1]), 'h04E);

    sel; wprefix(3'b010); waddr(6'd12); wnib(~model[12]);
    desel;
    chk(cmd_n == 2, "R7 no command", cmd_n, 2);
    do_read(6'd12, 1, "R7 memory untouched");

    sel; wprefix(3'b101); waddr(6'd14); wbit(1'b1); wbit(~model[14][1]);
    desel;
    do_read(6'd14, 1, "R1 partial word dropped");
    wr_n = 1'b0; dat_in = 1'b1; idle(4); wr_n = 1'b1; idle(4);
    rd_n = 1'b0; idle(4);
    chk(dat_oe === 1'b0, "R1 ignore while deselected", int'(dat_oe), 0);
    rd_n = 1'b1; idle(4);

    v = ~model[20];
    sel; wprefix(3'b101); waddr(6'd20);
    for (int i = 0; i < 3; i++) wbit(v[i]);
    wr_n = 1'b0; dat_in = v[3]; idle(4);
    wr_n = 1'b1; cs_n = 1'b1; idle(6);
    do_read(6'd20, 1, "R10 release beats store");
    scan_all("R9 scan final");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule